// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A synthesizable behavioural model of a word-organised static memory with a chip-style control interface. It has a shared bidirectional data bus split into two byte lanes and active-low controls: chip enable, write enable, output enable and one enable per lane. A write stores only the enabled lanes of the addressed word. A read drives only the enabled lanes onto the bus and leaves every other pin floating. The full part is 65,536 words of 16 bits, built with `ADDR_W = 16`. The default is a smaller depth, so that a quick elaboration stays light.

Writes are sampled on the rising edge of `clk`, which suits synthesis. Reads and all tristate decisions are combinational from the pins. A `standby` output reports that the chip is deselected.

Top module: `bytelane_sram`

## Requirements
- R1: When `ce_n` and `we_n` are both low at a rising `clk` edge, each lane whose enable is low stores its bus byte at `addr`. Lane 0 is `dq[7:0]` with enable `ben_n[0]`; lane 1 is `dq[15:8]` with enable `ben_n[1]`.
- R2: During a write, a lane whose enable is high keeps its previously stored byte.
- R3: When `ce_n` is low, `oe_n` is low and `we_n` is high, each lane whose enable is low drives the stored byte of word `addr` without waiting for a clock.
- R4: During a read, a lane whose enable is high is high-impedance while the other lane is driven.
- R5: While `ce_n` is high the model drives no bus pin.
- R6: While `oe_n` is high the model drives no bus pin.
- R7: While both lane enables are high the model drives no bus pin.
- R8: While `ce_n` and `we_n` are low the model drives no bus pin, even with `oe_n` low.
- R9: `standby` equals 1 exactly while `ce_n` is high. With `ce_n` high, a clock edge with `we_n` low changes no stored data.
- R10: Word 0 and the highest word are distinct locations; writing one does not alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write sampling clock |
| addr | input | ADDR_W | Word address |
| dq | inout | 16 | Bidirectional data bus, two byte lanes |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ben_n | input | 2 | Lane enables, active low; bit 0 is the low lane |
| standby | output | 1 | High while deselected |

## Verification
Assertions check several rules at every clock edge:
- a lane written with its enable low holds the bus byte afterwards, and a masked lane is unchanged;
- the output drivers stay off during a write, during deselect, and on a disabled lane;
- `standby` follows chip enable.

Floating pins are not visible as a value at the ports. The bench therefore drives a probe byte, the complement of the stored byte, onto any lane that must be floating. Any drive from the model then corrupts the probe. Only the bench's scenarios show the combinational read path, the aliasing between the lowest and highest word, and the full decode of each high-impedance condition.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr,
  inout  wire  [DATA_W-1:0]        dq,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic [DATA_W/LANE_W-1:0] ben_n,
  output logic                     standby
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata;
  logic              wr_act, rd_act;
  logic [LANES-1:0]  lane_oe;

  assign wr_act  = !ce_n && !we_n;
  assign rd_act  = !ce_n && !oe_n && we_n;
  assign standby = ce_n;
  assign rdata   = mem[addr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_act && !ben_n[i])
        mem[addr][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_oe[g] = rd_act && !ben_n[g];
    assign dq[g*LANE_W +: LANE_W] = lane_oe[g] ? rdata[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};

    assert_lane_store_R1: assert property (@(posedge clk)
      (wr_act && !ben_n[g]) |=> mem[$past(addr)][g*LANE_W +: LANE_W] == $past(dq[g*LANE_W +: LANE_W]));
    assert_lane_keep_R2: assert property (@(posedge clk)
      (wr_act && ben_n[g]) |=> mem[$past(addr)][g*LANE_W +: LANE_W] == $past(rdata[g*LANE_W +: LANE_W]));
    assert_lane_float_R4: assert property (@(posedge clk)
      ben_n[g] |-> !lane_oe[g]);
  end

  assert_write_quiet_R8: assert property (@(posedge clk) wr_act |-> lane_oe == '0);
  assert_oe_quiet_R6: assert property (@(posedge clk) oe_n |-> lane_oe == '0);
  assert_deselect_R9: assert property (@(posedge clk) ce_n |-> (standby && lane_oe == '0));
endmodule

// File: tb/test_bytelane_sram.sv
module test_bytelane_sram;
  localparam int AW = 10;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [1:0] ben_n = 2'b11;
  logic standby;
  logic [15:0] tb_d = '0;
  logic [1:0] tb_en = '0;
  wire  [15:0] dq;
  int checks = 0, errors = 0;

  for (genvar g = 0; g < 2; g++) begin : g_drv
    assign dq[g*8 +: 8] = tb_en[g] ? tb_d[g*8 +: 8] : 8'bz;
  end

  bytelane_sram #(.ADDR_W(AW)) i_bytelane_sram (
    .clk(clk), .addr(addr), .dq(dq), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .ben_n(ben_n), .standby(standby));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk);
    addr = a; tb_d = d; tb_en = 2'b11; ben_n = b; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    we_n = 1; ce_n = 1; tb_en = 0; ben_n = 2'b11;
  endtask

  task automatic do_read(string req, logic [AW-1:0] a, logic [15:0] exp);
    @(negedge clk);
    addr = a; tb_en = 0; ben_n = 2'b00; ce_n = 0; we_n = 1; oe_n = 0;
    #1 check(req, dq, exp);
    ce_n = 1; oe_n = 1; ben_n = 2'b11;
  endtask

  // Probe: bench drives the complement of the stored word on the lanes in mask;
  // any drive by the model there corrupts the probe.
  task automatic probe(string req, logic [1:0] mask, logic [15:0] stored, logic [15:0] exp);
    tb_d = ~stored; tb_en = mask;
    #1 check(req, dq, exp);
    tb_en = 0;
  endtask

  // {is_write, ben_n[1:0], addr[15:0], data[15:0]}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'b00, 16'h0005, 16'h1234},
    {1'b0, 2'b00, 16'h0005, 16'h1234},
    {1'b1, 2'b10, 16'h0005, 16'hABCD},
    {1'b0, 2'b00, 16'h0005, 16'h12CD},
    {1'b1, 2'b01, 16'h0005, 16'h7788},
    {1'b0, 2'b00, 16'h0005, 16'h77CD},
    {1'b1, 2'b11, 16'h0005, 16'hFFFF},
    {1'b0, 2'b00, 16'h0005, 16'h77CD},
    {1'b1, 2'b00, 16'h0000, 16'h0101},
    {1'b1, 2'b00, 16'h03FF, 16'h8080},
    {1'b0, 2'b00, 16'h0000, 16'h0101},
    {1'b0, 2'b00, 16'h03FF, 16'h8080}
  };

  initial begin
    fork
      begin
        #1 check("R9 standby at start", {15'b0, standby}, 16'h1);
        for (int i = 0; i < NV; i++) begin
          if (VEC[i][34]) do_write(VEC[i][16 +: AW], VEC[i][15:0], VEC[i][33:32]);
          else do_read("R1 R2 R10 table read", VEC[i][16 +: AW], VEC[i][15:0]);
        end
        // Word 5 holds 77CD from here on
        @(negedge clk);
        addr = 5; ce_n = 0; we_n = 1; oe_n = 0; ben_n = 2'b10;
        probe("R4 high lane floats", 2'b10, 16'h77CD, 16'h88CD);
        ben_n = 2'b01;
        probe("R4 low lane floats", 2'b01, 16'h77CD, 16'h7732);
        ben_n = 2'b00;
        #1 check("R3 async read", dq, 16'h77CD);
        ben_n = 2'b11;
        probe("R7 both lanes off", 2'b11, 16'h77CD, 16'h8832);
        ben_n = 2'b00; oe_n = 1;
        probe("R6 output disabled", 2'b11, 16'h77CD, 16'h8832);
        oe_n = 0; ce_n = 1;
        probe("R5 deselected", 2'b11, 16'h77CD, 16'h8832);
        check("R9 standby high", {15'b0, standby}, 16'h1);
        ce_n = 0;
        #1 check("R9 standby low", {15'b0, standby}, 16'h0);
        // Deselected write attempt must not store
        ce_n = 1; we_n = 0; tb_d = 16'h0F0F; tb_en = 2'b11;
        @(negedge clk);
        we_n = 1; tb_en = 0;
        do_read("R9 no write when deselected", 5, 16'h77CD);
        // Write with OE low: model must stay off the bus
        @(negedge clk);
        addr = 5; ce_n = 0; oe_n = 0; we_n = 0; ben_n = 2'b00;
        probe("R8 write keeps bus quiet", 2'b11, 16'h77CD, 16'h8832);
        tb_en = 2'b11;
        @(negedge clk);
        we_n = 1; ce_n = 1; tb_en = 0;
        do_read("R1 write with oe low stored", 5, 16'h8832);
        do_read("R10 word 0 intact", 0, 16'h0101);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule